// File: doc/BRIEF.md
# Base-and-Bounds Address Translation Unit

This block sits between the address generation of a small processor that runs in machine mode and user mode, and its memory port. Each cycle a request may present a virtual address together with the access kind (instruction fetch, data load or data store) and the privilege of the code issuing it. In the same cycle the block returns either an accepted pulse with the physical address, or a precise fault whose cause code tells the three access kinds apart. A faulting request produces no access at all.

Three translation modes are selectable. In bare mode addresses pass through unchanged. In unified mode every user access is relocated by adding one base value, and is legal only when it lies below one bound value. In split mode instruction fetches use one base/bound pair and data accesses use another, so several processes can share a single code segment. Machine-mode code is trusted and is never relocated. Every final address, in every mode and at every privilege, must fall inside a parameterised legal physical window. A configuration write port loads the mode, or a whole base/bound pair at once, so no request can see a pair that is half updated.

Top module: `bb_xlate`

## Requirements
- R1: After reset the mode is bare and both base/bound pairs are zero, so switching to unified mode without loading a pair makes every user access fault.
- R2: In bare mode (mode value 0) the physical address equals the virtual address for every privilege and access kind; only the physical window check applies.
- R3: In unified mode (mode value 1) a user access is legal only when its virtual address is below the code-pair bound; its physical address is the virtual address plus the code-pair base, for all access kinds.
- R4: In split mode (mode value 2) user fetches are relocated and bounded by the code pair, and user loads and stores by the data pair.
- R5: Accesses with req_priv = 1 (machine) are never relocated or bound-checked: the physical address equals the virtual address.
- R6: A final address is legal only when PHYS_LO <= address < PHYS_HI; otherwise the request faults, in every mode and at every privilege.
- R7: When adding the base to a user virtual address carries out of the AW-bit address, the request faults even if the wrapped result lies in the legal window.
- R8: Results are combinational in the request cycle. A fault raises rsp_fault with rsp_ok = 0 and rsp_paddr = 0; rsp_cause is 1 for a fetch (kind 0), 2 for a load (kind 1), 3 for a store (kind 2), and kind 3 is handled as a store. Without req_valid, rsp_ok, rsp_fault and rsp_cause are 0.
- R9: A configuration write with cfg_sel 0 loads the mode, cfg_sel 1 loads the code pair, cfg_sel 2 loads the data pair (base and bound together); cfg_sel 3 changes nothing. A write affects requests from the next cycle on; a request in the write cycle sees the old values.
- R10: A write of mode value 3 is ignored and the previous mode stays in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Write target: 0 mode, 1 code pair, 2 data pair, 3 none |
| cfg_base | input | AW | Base value for a pair write |
| cfg_bound | input | AW | Bound value for a pair write |
| cfg_mode | input | 2 | Mode value for a mode write |
| req_valid | input | 1 | Request present this cycle |
| req_vaddr | input | AW | Virtual address |
| req_kind | input | 2 | 0 fetch, 1 load, 2 store, 3 treated as store |
| req_priv | input | 1 | 1 machine, 0 user |
| rsp_ok | output | 1 | Request accepted this cycle |
| rsp_paddr | output | AW | Physical address, zero unless accepted |
| rsp_fault | output | 1 | Request faulted this cycle |
| rsp_cause | output | 2 | Fault cause by access kind |

## Verification
A configuration write and a translated request can fall in the same cycle, and the block must then translate with the old pair and switch only at the next edge. The bench drives a code-pair write that enlarges the bound together with a user load just above the old bound, judges a fault in that cycle, then keeps the load asserted after the edge and expects acceptance at the new base. The reserved write target and the reserved mode value are judged the same way, by repeating a request after the write and comparing its result with the unchanged configuration.

// File: rtl/bb_pkg.sv
package bb_pkg;

    typedef enum logic [1:0] {
        MODE_BARE  = 2'd0,
        MODE_UNI   = 2'd1,
        MODE_SPLIT = 2'd2,
        MODE_RSVD  = 2'd3
    } bb_mode_e;

    localparam logic [1:0] KIND_FETCH = 2'd0;
    localparam logic [1:0] KIND_LOAD  = 2'd1;

    localparam logic [1:0] SEL_MODE = 2'd0;
    localparam logic [1:0] SEL_CODE = 2'd1;
    localparam logic [1:0] SEL_DATA = 2'd2;

    localparam int unsigned NUM_SEG = 2;

    // cause code by access kind; the reserved kind reports as a store
    function automatic logic [1:0] fault_cause(logic [1:0] kind);
        case (kind)
            KIND_FETCH: return 2'd1;
            KIND_LOAD:  return 2'd2;
            default:    return 2'd3;
        endcase
    endfunction

endpackage

// File: rtl/bb_cfg_regs.sv
module bb_cfg_regs
    import bb_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [1:0]    sel,
    input  logic [AW-1:0] wr_base,
    input  logic [AW-1:0] wr_bound,
    input  logic [1:0]    wr_mode,
    output bb_mode_e      mode,
    output logic [AW-1:0] code_base,
    output logic [AW-1:0] code_bound,
    output logic [AW-1:0] data_base,
    output logic [AW-1:0] data_bound
);

    typedef struct packed {
        bb_mode_e      mode;
        logic [AW-1:0] code_base;
        logic [AW-1:0] code_bound;
        logic [AW-1:0] data_base;
        logic [AW-1:0] data_bound;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            case (sel)
                SEL_MODE: begin
                    if (wr_mode != MODE_RSVD) begin
                        cfg_d.mode = bb_mode_e'(wr_mode);
                    end
                end
                SEL_CODE: begin
                    cfg_d.code_base  = wr_base;
                    cfg_d.code_bound = wr_bound;
                end
                SEL_DATA: begin
                    cfg_d.data_base  = wr_base;
                    cfg_d.data_bound = wr_bound;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '{mode: MODE_BARE, default: '0};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign mode       = cfg_q.mode;
    assign code_base  = cfg_q.code_base;
    assign code_bound = cfg_q.code_bound;
    assign data_base  = cfg_q.data_base;
    assign data_bound = cfg_q.data_bound;

    // R9: a pair write lands whole at the next edge
    p_code_commit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        we && sel == SEL_CODE |=> code_base == $past(wr_base) && code_bound == $past(wr_bound));

    p_data_commit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        we && sel == SEL_DATA |=> data_base == $past(wr_base) && data_bound == $past(wr_bound));

    // R9: the unused target leaves every register alone
    p_rsvd_sel_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        we && sel == 2'd3 |=> $stable(mode) && $stable(code_base) && $stable(code_bound)
                            && $stable(data_base) && $stable(data_bound));

    // R10: the reserved mode value is refused
    p_mode_rsvd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        we && sel == SEL_MODE && wr_mode == 2'd3 |=> $stable(mode));

    p_mode_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mode != MODE_RSVD);

endmodule

// File: rtl/bb_seg_check.sv
module bb_seg_check #(
    parameter int unsigned AW = 32
) (
    input  logic [AW-1:0] vaddr,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] bound,
    output logic [AW-1:0] sum,
    output logic          wrap,
    output logic          over
);

    logic [AW:0] wide_sum;

    always_comb begin
        wide_sum = {1'b0, vaddr} + {1'b0, base};
        sum      = wide_sum[AW-1:0];
        wrap     = wide_sum[AW];
        over     = (vaddr >= bound);
    end

endmodule

// File: rtl/bb_phys_check.sv
module bb_phys_check #(
    parameter int unsigned   AW      = 32,
    parameter logic [AW-1:0] PHYS_LO = '0,
    parameter logic [AW-1:0] PHYS_HI = '1
) (
    input  logic [AW-1:0] paddr,
    output logic          bad
);

    always_comb begin
        bad = (paddr < PHYS_LO) || (paddr >= PHYS_HI);
    end

endmodule

// File: rtl/bb_xlate.sv
module bb_xlate
    import bb_pkg::*;
#(
    parameter int unsigned   AW      = 32,
    parameter logic [AW-1:0] PHYS_LO = AW'(32'h0000_1000),
    parameter logic [AW-1:0] PHYS_HI = AW'(32'h8000_0000)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [AW-1:0] cfg_base,
    input  logic [AW-1:0] cfg_bound,
    input  logic [1:0]    cfg_mode,
    input  logic          req_valid,
    input  logic [AW-1:0] req_vaddr,
    input  logic [1:0]    req_kind,
    input  logic          req_priv,
    output logic          rsp_ok,
    output logic [AW-1:0] rsp_paddr,
    output logic          rsp_fault,
    output logic [1:0]    rsp_cause
);

    localparam int unsigned SEG_W = $clog2(NUM_SEG);

    bb_mode_e      mode_q;
    logic [AW-1:0] code_base_q, code_bound_q, data_base_q, data_bound_q;

    bb_cfg_regs #(.AW(AW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (cfg_we),
        .sel        (cfg_sel),
        .wr_base    (cfg_base),
        .wr_bound   (cfg_bound),
        .wr_mode    (cfg_mode),
        .mode       (mode_q),
        .code_base  (code_base_q),
        .code_bound (code_bound_q),
        .data_base  (data_base_q),
        .data_bound (data_bound_q)
    );

    logic [AW-1:0] seg_base  [NUM_SEG];
    logic [AW-1:0] seg_bound [NUM_SEG];
    logic [AW-1:0] seg_sum   [NUM_SEG];
    logic          seg_wrap  [NUM_SEG];
    logic          seg_over  [NUM_SEG];

    assign seg_base[0]  = code_base_q;
    assign seg_bound[0] = code_bound_q;
    assign seg_base[1]  = data_base_q;
    assign seg_bound[1] = data_bound_q;

    // both segments evaluated in parallel; the pick happens after the adders
    for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
        bb_seg_check #(.AW(AW)) u_seg (
            .vaddr (req_vaddr),
            .base  (seg_base[g]),
            .bound (seg_bound[g]),
            .sum   (seg_sum[g]),
            .wrap  (seg_wrap[g]),
            .over  (seg_over[g])
        );
    end

    logic [SEG_W-1:0] pick;
    logic             relocate;
    logic [AW-1:0]    final_pa;
    logic             phys_bad;
    logic             seg_bad;
    logic             fault_now;

    always_comb begin
        pick     = (mode_q == MODE_SPLIT && req_kind != KIND_FETCH) ? SEG_W'(1) : SEG_W'(0);
        relocate = !req_priv && (mode_q == MODE_UNI || mode_q == MODE_SPLIT);
        final_pa = relocate ? seg_sum[pick] : req_vaddr;
        seg_bad  = relocate && (seg_wrap[pick] || seg_over[pick]);
    end

    bb_phys_check #(.AW(AW), .PHYS_LO(PHYS_LO), .PHYS_HI(PHYS_HI)) u_phys (
        .paddr (final_pa),
        .bad   (phys_bad)
    );

    always_comb begin
        fault_now = req_valid && (seg_bad || phys_bad);
        rsp_fault = fault_now;
        rsp_ok    = req_valid && !fault_now;
        rsp_paddr = rsp_ok ? final_pa : '0;
        rsp_cause = fault_now ? fault_cause(req_kind) : 2'd0;
    end

    // R8: a fault suppresses the access completely
    p_fault_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> !rsp_ok && rsp_paddr == '0 && rsp_cause != 2'd0);

    // R8: nothing happens without a request
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> !rsp_ok && !rsp_fault && rsp_cause == 2'd0);

    // R3: a user address at or above the active bound never gets through
    p_user_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_priv && mode_q != MODE_BARE
        && req_vaddr >= ((mode_q == MODE_SPLIT && req_kind != KIND_FETCH) ? data_bound_q : code_bound_q)
        |-> rsp_fault);

    // R5: machine accesses leave untranslated
    p_machine_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ok && req_priv |-> rsp_paddr == req_vaddr);

    // R6: every accepted address lies inside the legal window
    p_phys_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ok |-> rsp_paddr >= PHYS_LO && rsp_paddr < PHYS_HI);

endmodule

// File: tb/bb_xlate_tb.sv
module bb_xlate_tb;

    localparam int CLK_PERIOD = 10;
    localparam int AW         = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cfg_we;
    logic [1:0]    cfg_sel;
    logic [AW-1:0] cfg_base, cfg_bound;
    logic [1:0]    cfg_mode;
    logic          req_valid;
    logic [AW-1:0] req_vaddr;
    logic [1:0]    req_kind;
    logic          req_priv;
    logic          rsp_ok, rsp_fault;
    logic [AW-1:0] rsp_paddr;
    logic [1:0]    rsp_cause;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bb_xlate u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_base(cfg_base),
        .cfg_bound(cfg_bound), .cfg_mode(cfg_mode),
        .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_kind(req_kind), .req_priv(req_priv),
        .rsp_ok(rsp_ok), .rsp_paddr(rsp_paddr),
        .rsp_fault(rsp_fault), .rsp_cause(rsp_cause)
    );

    typedef struct packed {
        logic [1:0]  mode;
        logic        priv;
        logic [1:0]  kind;
        logic [31:0] va;
        logic        flt;
        logic [1:0]  cause;
        logic [31:0] pa;
        logic [3:0]  rq;
    } vec_t;

    // code pair: base 0x0010_0000 bound 0x1000; data pair: base 0x0020_0000 bound 0x2000
    // legal physical window 0x1000 .. 0x7FFF_FFFF
    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b0, 2'd1, 32'h0000_5000, 1'b0, 2'd0, 32'h0000_5000, 4'd2},  // R2 bare user load
        '{2'd0, 1'b0, 2'd0, 32'h0000_0800, 1'b1, 2'd1, 32'h0,         4'd6},  // R6 below window
        '{2'd0, 1'b1, 2'd2, 32'h9000_0000, 1'b1, 2'd3, 32'h0,         4'd6},  // R6 above window
        '{2'd1, 1'b0, 2'd0, 32'h0000_0FFC, 1'b0, 2'd0, 32'h0010_0FFC, 4'd3},  // R3 fetch in range
        '{2'd1, 1'b0, 2'd1, 32'h0000_1000, 1'b1, 2'd2, 32'h0,         4'd3},  // R3 load at bound
        '{2'd1, 1'b0, 2'd2, 32'h0000_0FFF, 1'b0, 2'd0, 32'h0010_0FFF, 4'd3},  // R3 last legal store
        '{2'd1, 1'b1, 2'd1, 32'h0000_3000, 1'b0, 2'd0, 32'h0000_3000, 4'd5},  // R5 machine untranslated
        '{2'd1, 1'b1, 2'd0, 32'h0000_0100, 1'b1, 2'd1, 32'h0,         4'd5},  // R5 machine still window-checked
        '{2'd2, 1'b0, 2'd0, 32'h0000_0800, 1'b0, 2'd0, 32'h0010_0800, 4'd4},  // R4 fetch uses code pair
        '{2'd2, 1'b0, 2'd1, 32'h0000_1800, 1'b0, 2'd0, 32'h0020_1800, 4'd4},  // R4 load uses data pair
        '{2'd2, 1'b0, 2'd0, 32'h0000_1800, 1'b1, 2'd1, 32'h0,         4'd4},  // R4 fetch past code bound
        '{2'd2, 1'b0, 2'd2, 32'h0000_2000, 1'b1, 2'd3, 32'h0,         4'd4},  // R4 store at data bound
        '{2'd2, 1'b0, 2'd3, 32'h0000_0004, 1'b0, 2'd0, 32'h0020_0004, 4'd8},  // R8 kind 3 as store
        '{2'd2, 1'b1, 2'd2, 32'h0004_0000, 1'b0, 2'd0, 32'h0004_0000, 4'd5}   // R5 machine in split
    };

    task automatic check(string tag, logic e_ok, logic e_flt, logic [1:0] e_cause, logic [AW-1:0] e_pa);
        n_checks++;
        if (rsp_ok !== e_ok || rsp_fault !== e_flt || rsp_cause !== e_cause || rsp_paddr !== e_pa) begin
            n_fails++;
            $display("FAIL %s: ok=%0b fault=%0b cause=%0d pa=%h expected ok=%0b fault=%0b cause=%0d pa=%h",
                     tag, rsp_ok, rsp_fault, rsp_cause, rsp_paddr, e_ok, e_flt, e_cause, e_pa);
        end
    endtask

    task automatic cfg_write(logic [1:0] sel, logic [AW-1:0] base, logic [AW-1:0] bound, logic [1:0] mode);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_base = base; cfg_bound = bound; cfg_mode = mode;
        @(posedge clk);
        #1;
        cfg_we = 1'b0;
    endtask

    task automatic do_req(logic priv, logic [1:0] kind, logic [AW-1:0] va);
        @(negedge clk);
        req_valid = 1'b1; req_priv = priv; req_kind = kind; req_vaddr = va;
        #1;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        cfg_we = 1'b0; cfg_sel = '0; cfg_base = '0; cfg_bound = '0; cfg_mode = '0;
        req_valid = 1'b0; req_vaddr = '0; req_kind = '0; req_priv = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R8 idle after reset", 1'b0, 1'b0, 2'd0, '0);

        // R1: bare after reset
        do_req(1'b0, 2'd1, 32'h0000_5000);
        check("R1 reset mode is bare", 1'b1, 1'b0, 2'd0, 32'h0000_5000);

        // R1: pairs cleared, so unified mode rejects every user access
        cfg_write(2'd0, '0, '0, 2'd1);
        do_req(1'b0, 2'd1, 32'h0000_0800);
        check("R1 cleared bound faults", 1'b0, 1'b1, 2'd2, '0);

        cfg_write(2'd1, 32'h0010_0000, 32'h0000_1000, 2'd0);
        cfg_write(2'd2, 32'h0020_0000, 32'h0000_2000, 2'd0);

        for (int i = 0; i < NV; i++) begin
            cfg_write(2'd0, '0, '0, VECS[i].mode);
            do_req(VECS[i].priv, VECS[i].kind, VECS[i].va);
            check($sformatf("R%0d vector %0d", VECS[i].rq, i),
                  !VECS[i].flt, VECS[i].flt, VECS[i].cause, VECS[i].pa);
        end

        // R9: write and request in the same cycle
        cfg_write(2'd0, '0, '0, 2'd1);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 2'd1; cfg_base = 32'h0030_0000; cfg_bound = 32'h0000_4000;
        req_valid = 1'b1; req_priv = 1'b0; req_kind = 2'd1; req_vaddr = 32'h0000_2000;
        #1;
        check("R9 same-cycle request sees old pair", 1'b0, 1'b1, 2'd2, '0);
        @(posedge clk);
        #1;
        cfg_we = 1'b0;
        check("R9 next-cycle request sees new pair", 1'b1, 1'b0, 2'd0, 32'h0030_2000);

        // R9: target 3 writes nothing
        cfg_write(2'd3, 32'h0050_0000, 32'h0000_0000, 2'd0);
        do_req(1'b0, 2'd1, 32'h0000_2000);
        check("R9 select 3 ignored", 1'b1, 1'b0, 2'd0, 32'h0030_2000);

        // R10: reserved mode refused, unified stays in force
        cfg_write(2'd1, 32'h0010_0000, 32'h0000_1000, 2'd0);
        cfg_write(2'd0, '0, '0, 2'd3);
        do_req(1'b0, 2'd1, 32'h0000_0800);
        check("R10 mode 3 ignored", 1'b1, 1'b0, 2'd0, 32'h0010_0800);

        // R7: carry out of the adder faults though the wrapped result is legal
        cfg_write(2'd1, 32'hFFFF_0000, 32'h0002_0000, 2'd0);
        do_req(1'b0, 2'd1, 32'h0001_2000);
        check("R7 wrap faults", 1'b0, 1'b1, 2'd2, '0);

        // R8: dropping valid silences the outputs
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        check("R8 no request", 1'b0, 1'b0, 2'd0, '0);

        repeat (2) @(posedge clk);
        finish_run();
    end

endmodule